// File: doc/BRIEF.md
# Executive Mode State Controller

This block tracks the operating state of a processor core and advances its program counter each time an instruction completes. After reset the core runs outside Executive mode. A console request moves it into Executive mode in the supervisory (Monitor) state. From Monitor State, a boundary-arm instruction sets a flag. The next completed jump then carries the core into the restricted user (Program) state.

While in Program State, the controller screens every completed instruction for privileged operations. These are a halt, an input/output or control opcode, or a register transfer that targets the protected low half of the register file. When it finds one, it suppresses the instruction: the program counter does not move. It also drops the core back to Monitor State and raises a one-cycle trap pulse. A six-bit condition register holds the state flags. A bulk write can load it, but outside Executive mode only the interrupt-enable bit can be changed.

Top module: `exec_state_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `pc` is 0, `exec_mode` is 0, `cond_reg` is 0 and `priv_trap` is 0.
- R2: On `instr_done`, the value of `exit_kind` selects how `pc` changes:
  - 2'b00 (normal) or 2'b11 adds 1, modulo 2^15.
  - 2'b01 (skip) adds 2, modulo 2^15.
  - 2'b10 (jump) loads `jump_addr`.
  - The new value is visible after the same clock edge.
- R3: A `console_exec_req` pulse sets `exec_mode` and clears the Program State flag (`cond_reg[5]`) and the Program State jump flag (`cond_reg[3]`).
- R4: An instruction completed with `arm_boundary` in Monitor State sets the boundary flag `cond_reg[0]`.
- R5: With the boundary flag set, the next completed jump exit in Monitor State sets `cond_reg[5]` and `cond_reg[3]` and clears `cond_reg[0]`. Normal and skip exits leave the state unchanged.
- R6: An instruction is privileged if any of the following holds:
  - it is a halt, meaning `op_major` is 0 and `op_sub[5:3]` is 0;
  - `op_major` is octal 71 to 77, except octal 77 with `op_sub` equal to octal 71 or 72;
  - `xfer_valid` is set with `xfer_reg` below octal 40.
- R7: When a privileged instruction completes in Program State, `pc` holds its value, `priv_trap` is 1 for exactly the next cycle, and `cond_reg[5]` and `cond_reg[3]` clear.
- R8: A non-privileged instruction completing in Program State updates `pc` per R2, leaves the core in Program State and gives no trap.
- R9: `priv_trap` never rises for an instruction that completes outside Program State.
- R10: A `cr_write` with no `instr_done` and no console request loads `cond_reg` from `cr_wdata` in Executive mode. Outside Executive mode it loads only bit 4, and the other bits stay 0.
- R11: A `cr_write` in the same cycle as `instr_done` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| console_exec_req | input | 1 | Console request to enter Executive Monitor State |
| instr_done | input | 1 | Instruction completion strobe |
| exit_kind | input | 2 | Exit type: 00 normal, 01 skip, 10 jump |
| jump_addr | input | 15 | Execution address of a jump |
| op_major | input | 6 | Major opcode of the completing instruction |
| op_sub | input | 6 | Sub-code of the completing instruction |
| xfer_valid | input | 1 | Completing instruction is an inter-register transfer |
| xfer_reg | input | 6 | Register-file entry targeted by the transfer |
| arm_boundary | input | 1 | Completing instruction is the boundary-arm instruction |
| cr_write | input | 1 | Bulk write strobe for the condition register |
| cr_wdata | input | 6 | Bulk write data |
| pc | output | 15 | Program counter |
| exec_mode | output | 1 | Executive mode active |
| program_state | output | 1 | Program State active (Executive mode only) |
| cond_reg | output | 6 | Condition register flags |
| priv_trap | output | 1 | One-cycle privileged-operation trap |

## Verification
The privilege screen is swept over every major opcode, each combined with several sub-codes. The sub-codes are chosen to separate the halt pattern, the two exempt control sub-codes and ordinary ones. A second sweep covers all 64 transfer targets, which finds the protected boundary at octal 40. Each swept instruction is issued from a fresh Program State entry, so a wrong trap, a moved counter or a retained state flag shows up per opcode. Exit-type tests wrap the counter at its top value. Arming, bulk-write and collision cases separate the effects of Monitor State, Program State and non-Executive mode.

// File: rtl/exec_state_pkg.sv
// Shared constants and types for the executive state controller.
// Assumes a six-bit condition register with fixed flag positions.
package exec_state_pkg;
    typedef enum logic [1:0] {
        EXIT_NORMAL = 2'b00,
        EXIT_SKIP   = 2'b01,
        EXIT_JUMP   = 2'b10,
        EXIT_RSVD   = 2'b11
    } exit_kind_e;

    localparam int CR_W        = 6;
    localparam int CR_BOUNDARY = 0;
    localparam int CR_DLOAD    = 1;
    localparam int CR_OPREL    = 2;
    localparam int CR_PSJUMP   = 3;
    localparam int CR_INTEN    = 4;
    localparam int CR_PSTATE   = 5;

    localparam logic [5:0] OP_HALT     = 6'o00;
    localparam logic [5:0] OP_PRIV_LO  = 6'o71;
    localparam logic [5:0] OP_CTRL     = 6'o77;
    localparam logic [5:0] SUB_EXEMPT0 = 6'o71;
    localparam logic [5:0] SUB_EXEMPT1 = 6'o72;
    localparam logic [5:0] REG_PROT_HI = 6'o40;
endpackage

// File: rtl/exec_pc_unit.sv
// Program counter update at instruction completion.
// Assumes suppress is asserted only together with done.
module exec_pc_unit
    import exec_state_pkg::*;
#(
    parameter int PC_W = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            done,
    input  logic            suppress,
    input  logic [1:0]      exit_kind,
    input  logic [PC_W-1:0] jump_addr,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] STEP1 = PC_W'(1);
    localparam logic [PC_W-1:0] STEP2 = PC_W'(2);

    // Advance, skip or load the counter when an instruction retires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (done && !suppress) begin
            case (exit_kind)
                EXIT_SKIP: pc <= pc + STEP2;
                EXIT_JUMP: pc <= jump_addr;
                default:   pc <= pc + STEP1;
            endcase
        end
    end

    a_r7_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && suppress) |=> $stable(pc));
    a_r2_skip_step: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !suppress && exit_kind == EXIT_SKIP) |=> pc == $past(pc) + STEP2);
    a_r2_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !suppress && exit_kind == EXIT_JUMP) |=> pc == $past(jump_addr));
endmodule

// File: rtl/exec_priv_decode.sv
// Classifies a completing instruction as privileged for Program State.
// Pure combinational; the caller qualifies it with state and strobe.
module exec_priv_decode
    import exec_state_pkg::*;
(
    input  logic [5:0] op_major,
    input  logic [5:0] op_sub,
    input  logic       xfer_valid,
    input  logic [5:0] xfer_reg,
    output logic       priv
);
    logic is_halt, is_ctrl, is_exempt, is_prot_xfer;

    // Split the opcode into its privileged categories.
    always_comb begin
        is_halt      = (op_major == OP_HALT) && (op_sub[5:3] == 3'd0);
        is_exempt    = (op_major == OP_CTRL) &&
                       ((op_sub == SUB_EXEMPT0) || (op_sub == SUB_EXEMPT1));
        is_ctrl      = (op_major >= OP_PRIV_LO) && !is_exempt;
        is_prot_xfer = xfer_valid && (xfer_reg < REG_PROT_HI);
        priv         = is_halt || is_ctrl || is_prot_xfer;
    end
endmodule

// File: rtl/exec_cr_state.sv
// Executive mode flag, condition register and trap pulse.
// Assumes done/arm are single-cycle strobes from the retire stage.
module exec_cr_state
    import exec_state_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            console_req,
    input  logic            done,
    input  logic [1:0]      exit_kind,
    input  logic            arm,
    input  logic            priv_op,
    input  logic            cr_wr,
    input  logic [CR_W-1:0] cr_wdata,
    output logic            exec_mode,
    output logic [CR_W-1:0] cr,
    output logic            suppress,
    output logic            trap
);
    logic in_prog, in_monitor;

    // Derive the current state and whether this retirement is blocked.
    always_comb begin
        in_prog    = exec_mode && cr[CR_PSTATE];
        in_monitor = exec_mode && !cr[CR_PSTATE];
        suppress   = done && in_prog && priv_op;
    end

    // Sequence state transitions, flag updates and the trap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_mode <= 1'b0;
            cr        <= '0;
            trap      <= 1'b0;
        end else begin
            trap <= suppress;
            if (console_req) begin
                exec_mode      <= 1'b1;
                cr[CR_PSTATE]  <= 1'b0;
                cr[CR_PSJUMP]  <= 1'b0;
            end else if (done) begin
                if (suppress) begin
                    cr[CR_PSTATE] <= 1'b0;
                    cr[CR_PSJUMP] <= 1'b0;
                end else if (in_monitor && cr[CR_BOUNDARY] && exit_kind == EXIT_JUMP) begin
                    cr[CR_PSTATE]   <= 1'b1;
                    cr[CR_PSJUMP]   <= 1'b1;
                    cr[CR_BOUNDARY] <= 1'b0;
                end else if (in_monitor && arm) begin
                    cr[CR_BOUNDARY] <= 1'b1;
                end
            end else if (cr_wr) begin
                if (exec_mode) cr <= cr_wdata;
                else           cr[CR_INTEN] <= cr_wdata[CR_INTEN];
            end
        end
    end

    a_r3_console_enter: assert property (@(posedge clk) disable iff (!rst_n)
        console_req |=> (exec_mode && !cr[CR_PSTATE]));
    a_r10_bits_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_mode |-> (cr & ~(CR_W'(1) << CR_INTEN)) == '0);
    a_r7_trap_drops_state: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !cr[CR_PSTATE]);
    a_r9_no_trap_monitor: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !in_prog) |=> !trap);
    a_r5_entry_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cr[CR_PSTATE]) |-> $past(cr[CR_BOUNDARY]) || $past(cr_wr));
endmodule

// File: rtl/exec_state_ctrl.sv
// Top of the executive state controller: tracks mode/state, retires
// instructions into the program counter and traps privileged operations
// attempted in Program State. Assumes one retirement per cycle at most.
module exec_state_ctrl
    import exec_state_pkg::*;
#(
    parameter int PC_W = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            console_exec_req,
    input  logic            instr_done,
    input  logic [1:0]      exit_kind,
    input  logic [PC_W-1:0] jump_addr,
    input  logic [5:0]      op_major,
    input  logic [5:0]      op_sub,
    input  logic            xfer_valid,
    input  logic [5:0]      xfer_reg,
    input  logic            arm_boundary,
    input  logic            cr_write,
    input  logic [CR_W-1:0] cr_wdata,
    output logic [PC_W-1:0] pc,
    output logic            exec_mode,
    output logic            program_state,
    output logic [CR_W-1:0] cond_reg,
    output logic            priv_trap
);
    logic priv_op, suppress;

    exec_priv_decode u_decode (
        .op_major  (op_major),
        .op_sub    (op_sub),
        .xfer_valid(xfer_valid),
        .xfer_reg  (xfer_reg),
        .priv      (priv_op)
    );

    exec_cr_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .console_req(console_exec_req),
        .done       (instr_done),
        .exit_kind  (exit_kind),
        .arm        (arm_boundary),
        .priv_op    (priv_op),
        .cr_wr      (cr_write),
        .cr_wdata   (cr_wdata),
        .exec_mode  (exec_mode),
        .cr         (cond_reg),
        .suppress   (suppress),
        .trap       (priv_trap)
    );

    exec_pc_unit #(.PC_W(PC_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (instr_done),
        .suppress (suppress),
        .exit_kind(exit_kind),
        .jump_addr(jump_addr),
        .pc       (pc)
    );

    // Program State is meaningful only inside Executive mode.
    always_comb program_state = exec_mode && cond_reg[CR_PSTATE];

    a_r7_trap_single: assert property (@(posedge clk) disable iff (!rst_n)
        priv_trap |=> !priv_trap || $past(instr_done));
    a_r8_keep_state: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && program_state && !priv_op && !console_exec_req) |=> program_state);
endmodule

// File: tb/tb_exec_state_ctrl.sv
module tb_exec_state_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        console_exec_req = 1'b0;
    logic        instr_done = 1'b0;
    logic [1:0]  exit_kind = 2'b00;
    logic [14:0] jump_addr = '0;
    logic [5:0]  op_major = 6'o01;
    logic [5:0]  op_sub = '0;
    logic        xfer_valid = 1'b0;
    logic [5:0]  xfer_reg = '0;
    logic        arm_boundary = 1'b0;
    logic        cr_write = 1'b0;
    logic [5:0]  cr_wdata = '0;
    logic [14:0] pc;
    logic        exec_mode, program_state, priv_trap;
    logic [5:0]  cond_reg;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    exec_state_ctrl dut (
        .clk(clk), .rst_n(rst_n), .console_exec_req(console_exec_req),
        .instr_done(instr_done), .exit_kind(exit_kind), .jump_addr(jump_addr),
        .op_major(op_major), .op_sub(op_sub), .xfer_valid(xfer_valid),
        .xfer_reg(xfer_reg), .arm_boundary(arm_boundary), .cr_write(cr_write),
        .cr_wdata(cr_wdata), .pc(pc), .exec_mode(exec_mode),
        .program_state(program_state), .cond_reg(cond_reg), .priv_trap(priv_trap)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        console_exec_req = 0; instr_done = 0; exit_kind = 0; arm_boundary = 0;
        cr_write = 0; xfer_valid = 0; op_major = 6'o01; op_sub = 0;
    endtask

    // One instruction retirement, outputs sampled one negedge later.
    task automatic retire(input logic [1:0] k, input logic [14:0] a,
                          input logic [5:0] maj, input logic [5:0] sub,
                          input logic xv, input logic [5:0] xr, input logic arm);
        instr_done = 1; exit_kind = k; jump_addr = a; op_major = maj;
        op_sub = sub; xfer_valid = xv; xfer_reg = xr; arm_boundary = arm;
        @(negedge clk);
        idle();
    endtask

    task automatic console();
        console_exec_req = 1;
        @(negedge clk);
        idle();
    endtask

    function automatic bit exp_priv(input int maj, input int sub, input bit xv, input int xr);
        bit h, c, t;
        h = (maj == 0) && (sub / 8 == 0);
        c = (maj >= 57) && !(maj == 63 && (sub == 57 || sub == 58));
        t = xv && (xr < 32);
        return h || c || t;
    endfunction

    // Enter Program State fresh, then retire the instruction under test.
    task automatic try_op(input int maj, input int sub, input bit xv, input int xr);
        bit p;
        console();
        retire(2'b00, 0, 6'o01, 0, 0, 0, 1);
        retire(2'b10, 15'h1234, 6'o01, 0, 0, 0, 0);
        chk("R5 entry", program_state, 1);
        retire(2'b00, 0, 6'(maj), 6'(sub), xv, 6'(xr), 0);
        p = exp_priv(maj, sub, xv, xr);
        chk(p ? "R7 trap" : "R8 no trap", priv_trap, p);
        chk(p ? "R7 pc hold" : "R8 pc step", pc, p ? 'h1234 : 'h1235);
        chk(p ? "R7 state drop" : "R8 state keep", program_state, !p);
        @(negedge clk);
        chk("R7 pulse width", priv_trap, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 pc", pc, 0);
        chk("R1 exec", exec_mode, 0);
        chk("R1 cr", cond_reg, 0);
        chk("R1 trap", priv_trap, 0);

        // R10 outside Executive mode: only bit 4 loads
        cr_write = 1; cr_wdata = 6'b111111; @(negedge clk); idle();
        chk("R10 outside", cond_reg, 6'b010000);
        // R9 privileged op outside Executive mode
        retire(2'b00, 0, 6'o77, 0, 0, 0, 0);
        chk("R9 no trap non-exec", priv_trap, 0);
        chk("R2 normal", pc, 1);
        retire(2'b01, 0, 6'o01, 0, 0, 0, 0);
        chk("R2 skip", pc, 3);
        retire(2'b10, 15'h7FFF, 6'o01, 0, 0, 0, 0);
        chk("R2 jump", pc, 'h7FFF);
        retire(2'b00, 0, 6'o01, 0, 0, 0, 0);
        chk("R2 normal wrap", pc, 0);
        retire(2'b10, 15'h7FFF, 6'o01, 0, 0, 0, 0);
        retire(2'b01, 0, 6'o01, 0, 0, 0, 0);
        chk("R2 skip wrap", pc, 1);
        retire(2'b11, 0, 6'o01, 0, 0, 0, 0);
        chk("R2 reserved as normal", pc, 2);

        console();
        chk("R3 exec", exec_mode, 1);
        chk("R3 monitor", program_state, 0);
        // R9 privileged op in Monitor State
        retire(2'b00, 0, 6'o00, 0, 0, 0, 0);
        chk("R9 no trap monitor", priv_trap, 0);
        // R4 arm, R5 non-jump exits do not enter
        retire(2'b00, 0, 6'o01, 0, 0, 0, 1);
        chk("R4 arm", cond_reg, 6'b010001);
        retire(2'b01, 0, 6'o01, 0, 0, 0, 0);
        chk("R5 skip no entry", program_state, 0);
        retire(2'b10, 15'h0100, 6'o01, 0, 0, 0, 0);
        chk("R5 jump entry", cond_reg, 6'b111000);
        chk("R5 entry pc", pc, 'h0100);
        // R10 full write inside Executive mode
        cr_write = 1; cr_wdata = 6'b000110; @(negedge clk); idle();
        chk("R10 exec write", cond_reg, 6'b000110);
        // R11 collision: write ignored
        cr_write = 1; cr_wdata = 6'b111111; instr_done = 1; exit_kind = 0;
        @(negedge clk); idle();
        chk("R11 ignored", cond_reg, 6'b000110);
        chk("R11 pc", pc, 'h0101);
        cr_write = 1; cr_wdata = 6'b000000; @(negedge clk); idle();

        // R6 sweep over major opcodes and chosen sub-codes
        for (int m = 0; m < 64; m++) begin
            try_op(m, 0, 0, 0);
            try_op(m, 12, 0, 0);
            if (m >= 56) begin
                try_op(m, 57, 0, 0);
                try_op(m, 58, 0, 0);
                try_op(m, 59, 0, 0);
            end
        end
        // R6 sweep over transfer targets
        for (int r = 0; r < 64; r++) try_op(6'o53, 0, 1, r);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule